// File: doc/BRIEF.md
# Configurable Pixel Format Packer

This block sits at the tail of a writeback path. It takes a stream of pixels carrying 8 bits per channel and turns them into the 32-bit words that memory expects. A static 4-bit format code picks the bit depth and the channel order. The available layouts are 16-bit 4:4:4:4, 16-bit 5:6:5, 24-bit 8:8:8 and 32-bit 8:8:8:8. Depth reduction drops the low-order bits of each channel. The code also decides how many pixels share one word, and the packer handles that.

Alpha is handled by two controls. When alpha storage is on, the pixel's alpha goes into the alpha field, complemented if the invert control is set. When it is off, the alpha field is padding, and the invert control chooses whether that padding is all ones or all zeros. A 4-bit lane mask gates the strobe of each byte position in every output word.

Pixels enter on a valid/ready stream, with a marker on the last pixel of each line. Words leave on a valid/ready stream with a 4-bit byte strobe and an end-of-line marker. At the end of a line, a partly filled word is flushed with its empty lanes strobed off.

Top module: `pix_fmt_packer`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The input pixel is `in_pix[31:24]`=red, `[23:16]`=green, `[15:8]`=blue, `[7:0]`=alpha. Output words are little-endian: byte k is `out_data[8k+7:8k]`. Each format name lists channels from the most significant bit down. The 32-bit codes are 12 ABGR, 13 ARGB, 14 BGRA and 15 RGBA. Each pixel gives one word whose strobe equals the lane mask.
- R3: Codes 0 ABGR, 1 ARGB, 2 BGRA and 3 RGBA are 16-bit with 4 bits per channel, taken from the top 4 bits of each input channel. Two pixels share a word, and the first pixel of the pair sits in bits 15:0.
- R4: Code 6 is BGR and code 7 is RGB, both 16-bit with 5, 6 and 5 bits from the top of each channel. They pack two pixels per word like R3, and alpha is not stored.
- R5: Code 8 is BGR and code 9 is RGB, both 24-bit. The 3 bytes of each pixel go least significant first into a continuous byte stream, and each run of 4 bytes forms one word, so four pixels fill three words.
- R6: On the last pixel of a line, any partly filled word is sent with its empty lanes holding zero and strobed off. `out_last` is 1 exactly on the final word of the line, and a new line starts at lane 0.
- R7: With alpha storage on, the alpha field holds the input alpha when invert is 0, and its complement when invert is 1.
- R8: With alpha storage off, the alpha field of the 4444 and 8888 codes is all ones when invert is 1 and all zeros when invert is 0.
- R9: Bit k of the lane mask gates the strobe of byte k in every word. No strobe is high whose mask bit is 0.
- R10: Codes 4, 5, 10 and 11 give one all-zero word per pixel with all strobes low.
- R11: While `out_valid` is 1 and `out_ready` is 0, the output word is held unchanged and `in_ready` is 0. Every word is delivered once, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_fmt | input | 4 | Output format code, static during a line |
| cfg_alpha_en | input | 1 | Store the alpha channel |
| cfg_alpha_inv | input | 1 | Complement stored alpha, or choose the padding value |
| cfg_byte_en | input | 4 | Per-lane strobe mask |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high together with `in_valid` |
| in_pix | input | 32 | Pixel: red, green, blue, alpha from the top byte down |
| in_last | input | 1 | Last pixel of a line |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 32 | Packed word |
| out_strb | output | 4 | Byte strobes |
| out_last | output | 1 | Final word of a line |

## Verification
In a 24-bit line, the last pixel can complete one word and still leave bytes over. The second, partial word is then owed to the consumer in the same cycles in which the first pixel of the next line is already being offered. The bench sends lines back to back with odd lengths under random `out_ready` stalls, so that this flush collides with new input and with backpressure. The per-clock model judges the result: the flushed word must come out before any byte of the next line, and with the right strobes and end marker.

// File: rtl/pix_fmt_pkg.sv
package pix_fmt_pkg;
    localparam int LANES    = 4;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = LANES * BYTE_W;
    localparam int FMT_W    = 4;
    localparam int RES_N    = LANES - 1;
    localparam int CMB_N    = 2 * LANES;
    localparam int CNT_W    = $clog2(LANES);
    localparam int TOT_W    = $clog2(CMB_N);

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t [RES_N-1:0] rb;
        logic  [RES_N-1:0] rl;
        logic  [CNT_W-1:0] cnt;
        logic              flush;
        logic              ov;
        byte_t [LANES-1:0] od;
        logic  [LANES-1:0] os;
        logic              ol;
    } pk_state_t;
endpackage

// File: rtl/pix_fmt_alpha.sv
module pix_fmt_alpha
    import pix_fmt_pkg::*;
(
    input  byte_t a_in,
    input  logic  en,
    input  logic  inv,
    output byte_t a_out
);
    always_comb begin
        if (en) a_out = inv ? ~a_in : a_in;
        else    a_out = {BYTE_W{inv}};
    end
endmodule

// File: rtl/pix_fmt_encode.sv
module pix_fmt_encode
    import pix_fmt_pkg::*;
(
    input  logic [WORD_W-1:0] pix,
    input  byte_t             alpha,
    input  logic [FMT_W-1:0]  fmt,
    output byte_t [LANES-1:0] enc_b,
    output logic  [TOT_W-1:0] enc_n,
    output logic  [LANES-1:0] enc_live
);
    byte_t r, g, b, hi, lo;
    logic [WORD_W-1:0] v;

    always_comb begin
        r  = pix[31:24];
        g  = pix[23:16];
        b  = pix[15:8];
        // bit 0 of the code puts red in the upper colour slot
        hi = fmt[0] ? r : b;
        lo = fmt[0] ? b : r;
        v        = '0;
        enc_n    = TOT_W'(LANES);
        enc_live = '1;
        case (fmt)
            4'd0, 4'd1, 4'd2, 4'd3: begin
                // bit 1 moves alpha from the top nibble to the bottom one
                if (fmt[1]) v[15:0] = {hi[7:4], g[7:4], lo[7:4], alpha[7:4]};
                else        v[15:0] = {alpha[7:4], hi[7:4], g[7:4], lo[7:4]};
                enc_n = TOT_W'(2);
            end
            4'd6, 4'd7: begin
                v[15:0] = {hi[7:3], g[7:2], lo[7:3]};
                enc_n   = TOT_W'(2);
            end
            4'd8, 4'd9: begin
                v[23:0] = {hi, g, lo};
                enc_n   = TOT_W'(3);
            end
            4'd12, 4'd13, 4'd14, 4'd15: begin
                if (fmt[1]) v = {hi, g, lo, alpha};
                else        v = {alpha, hi, g, lo};
            end
            default: begin
                enc_live = '0;
            end
        endcase
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign enc_b[l] = v[l*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/pix_fmt_packer.sv
module pix_fmt_packer
    import pix_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FMT_W-1:0]  cfg_fmt,
    input  logic              cfg_alpha_en,
    input  logic              cfg_alpha_inv,
    input  logic [LANES-1:0]  cfg_byte_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_pix,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic [LANES-1:0]  out_strb,
    output logic              out_last
);
    pk_state_t st_q, st_d;

    byte_t             alpha_v;
    byte_t [LANES-1:0] enc_b;
    logic  [TOT_W-1:0] enc_n;
    logic  [LANES-1:0] enc_live;

    pix_fmt_alpha u_alpha (
        .a_in  (in_pix[7:0]),
        .en    (cfg_alpha_en),
        .inv   (cfg_alpha_inv),
        .a_out (alpha_v)
    );

    pix_fmt_encode u_enc (
        .pix      (in_pix),
        .alpha    (alpha_v),
        .fmt      (cfg_fmt),
        .enc_b    (enc_b),
        .enc_n    (enc_n),
        .enc_live (enc_live)
    );

    logic              slot_free;
    byte_t [CMB_N-1:0] cb;
    logic  [CMB_N-1:0] cl;
    logic  [TOT_W-1:0] total, rem, rel;
    byte_t [LANES-1:0] word_b;
    logic  [LANES-1:0] word_l;
    logic              emit, emit_last;

    always_comb begin
        st_d      = st_q;
        slot_free = !st_q.ov || out_ready;
        word_b    = '0;
        word_l    = '0;
        emit      = 1'b0;
        emit_last = 1'b0;
        rem       = '0;
        if (st_q.ov && out_ready) st_d.ov = 1'b0;

        // residual bytes first, then the new pixel's bytes
        cb = '0;
        cl = '0;
        for (int k = 0; k < CMB_N; k++) begin
            rel = TOT_W'(k) - TOT_W'(st_q.cnt);
            if (k < RES_N && TOT_W'(k) < TOT_W'(st_q.cnt)) begin
                cb[k] = st_q.rb[k];
                cl[k] = st_q.rl[k];
            end else if (TOT_W'(k) >= TOT_W'(st_q.cnt) && rel < enc_n) begin
                cb[k] = enc_b[rel[CNT_W-1:0]];
                cl[k] = enc_live[rel[CNT_W-1:0]];
            end
        end
        total = TOT_W'(st_q.cnt) + enc_n;

        if (st_q.flush) begin
            if (slot_free) begin
                word_b[RES_N-1:0] = st_q.rb;
                word_l[RES_N-1:0] = st_q.rl;
                emit      = 1'b1;
                emit_last = 1'b1;
                st_d.flush = 1'b0;
                st_d.cnt   = '0;
                st_d.rb    = '0;
                st_d.rl    = '0;
            end
        end else if (in_valid && slot_free) begin
            if (total >= TOT_W'(LANES)) begin
                word_b   = cb[LANES-1:0];
                word_l   = cl[LANES-1:0];
                emit     = 1'b1;
                rem      = total - TOT_W'(LANES);
                st_d.rb  = cb[LANES+RES_N-1:LANES];
                st_d.rl  = cl[LANES+RES_N-1:LANES];
                st_d.cnt = rem[CNT_W-1:0];
                if (in_last) begin
                    if (rem == '0) emit_last  = 1'b1;
                    else           st_d.flush = 1'b1;
                end
            end else if (in_last) begin
                word_b    = cb[LANES-1:0];
                word_l    = cl[LANES-1:0];
                emit      = 1'b1;
                emit_last = 1'b1;
                st_d.cnt  = '0;
                st_d.rb   = '0;
                st_d.rl   = '0;
            end else begin
                st_d.rb  = cb[RES_N-1:0];
                st_d.rl  = cl[RES_N-1:0];
                st_d.cnt = total[CNT_W-1:0];
            end
        end

        if (emit) begin
            st_d.ov = 1'b1;
            st_d.od = word_b;
            st_d.os = word_l & cfg_byte_en;
            st_d.ol = emit_last;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready  = slot_free && !st_q.flush;
    assign out_valid = st_q.ov;
    assign out_data  = st_q.od;
    assign out_strb  = st_q.os;
    assign out_last  = st_q.ol;
endmodule

// File: rtl/pix_fmt_checker.sv
module pix_fmt_checker
    import pix_fmt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [FMT_W-1:0]  cfg_fmt,
    input logic [LANES-1:0]  cfg_byte_en,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic [LANES-1:0]  out_strb,
    input logic              out_last
);
    logic fmt_unused;
    assign fmt_unused = (cfg_fmt == 4'd4) || (cfg_fmt == 4'd5) ||
                        (cfg_fmt == 4'd10) || (cfg_fmt == 4'd11);

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);

    assert_full_word_strb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_fmt[3:2] == 2'b11) |-> (out_strb == cfg_byte_en));

    assert_strb_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_strb & ~cfg_byte_en) == '0));

    assert_unused_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fmt_unused) |-> (out_strb == '0 && out_data == '0));

    assert_word_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                       $stable(out_strb) && $stable(out_last)));

    assert_input_stalled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
endmodule

bind pix_fmt_packer pix_fmt_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_fmt     (cfg_fmt),
    .cfg_byte_en (cfg_byte_en),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_strb    (out_strb),
    .out_last    (out_last)
);

// File: tb/sim_pix_fmt_packer.sv
module sim_pix_fmt_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_fmt = 4'd13;
    logic        cfg_alpha_en = 1'b1;
    logic        cfg_alpha_inv = 1'b0;
    logic [3:0]  cfg_byte_en = 4'hF;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_pix = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic [3:0]  out_strb;
    logic        out_last;

    always #10 clk = ~clk;   // 50 MHz

    pix_fmt_packer u0 (.*);

    typedef struct {
        logic [31:0] d;
        logic [3:0]  s;
        logic        l;
        string       r;
    } exp_t;

    exp_t        expq[$];
    logic [8:0]  lineq[$];
    int          n_chk = 0;
    int          n_fail = 0;
    string       cur_req = "R1";
    bit          rand_ready = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    function automatic logic [31:0] pixgen(int i);
        return {8'(i * 37 + 5), 8'(i * 91 + 17), 8'(i * 13 + 200), 8'(i * 59 + 3)};
    endfunction

    // Expected bytes of one pixel, least significant first
    function automatic void ref_bytes(input logic [31:0] p, input logic [3:0] f,
                                      input logic ae, input logic ai,
                                      output logic [31:0] v, output int n, output bit lv);
        logic [7:0] rr, gg, bb, aa, av;
        rr = p[31:24]; gg = p[23:16]; bb = p[15:8]; aa = p[7:0];
        if (ae) av = ai ? ~aa : aa;
        else    av = ai ? 8'hFF : 8'h00;
        v = '0; n = 4; lv = 1;
        case (f)
            4'd0:  begin v[15:0] = {av[7:4], bb[7:4], gg[7:4], rr[7:4]}; n = 2; end
            4'd1:  begin v[15:0] = {av[7:4], rr[7:4], gg[7:4], bb[7:4]}; n = 2; end
            4'd2:  begin v[15:0] = {bb[7:4], gg[7:4], rr[7:4], av[7:4]}; n = 2; end
            4'd3:  begin v[15:0] = {rr[7:4], gg[7:4], bb[7:4], av[7:4]}; n = 2; end
            4'd6:  begin v[15:0] = {bb[7:3], gg[7:2], rr[7:3]}; n = 2; end
            4'd7:  begin v[15:0] = {rr[7:3], gg[7:2], bb[7:3]}; n = 2; end
            4'd8:  begin v[23:0] = {bb, gg, rr}; n = 3; end
            4'd9:  begin v[23:0] = {rr, gg, bb}; n = 3; end
            4'd12: v = {av, bb, gg, rr};
            4'd13: v = {av, rr, gg, bb};
            4'd14: v = {bb, gg, rr, av};
            4'd15: v = {rr, gg, bb, av};
            default: lv = 0;
        endcase
    endfunction

    task automatic push_word(input logic lst);
        exp_t e;
        logic [8:0] x;
        e.d = '0; e.s = '0; e.r = cur_req;
        for (int k = 0; k < 4; k++) begin
            x = (lineq.size() > 0) ? lineq.pop_front() : 9'h000;
            e.d[8*k +: 8] = x[7:0];
            e.s[k] = x[8] & cfg_byte_en[k];
        end
        e.l = lst;
        expq.push_back(e);
    endtask

    task automatic model_accept(input logic [31:0] p, input logic lst);
        logic [31:0] v;
        int n;
        bit lv;
        ref_bytes(p, cfg_fmt, cfg_alpha_en, cfg_alpha_inv, v, n, lv);
        for (int k = 0; k < n; k++) lineq.push_back({lv, v[8*k +: 8]});
        while (lineq.size() >= 4) push_word(lst && lineq.size() == 4);
        if (lst && lineq.size() > 0) push_word(1'b1);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // per-clock monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    check(0, "R11", "word with none expected", {28'h0, out_strb, out_data}, 64'h0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(out_data == e.d && out_strb == e.s && out_last == e.l, e.r,
                          "word {last,strb,data}",
                          {27'h0, out_last, out_strb, out_data}, {27'h0, e.l, e.s, e.d});
                end
            end
            if (in_valid && in_ready) model_accept(in_pix, in_last);
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            #4;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = rand_ready ? (lfsr[0] | lfsr[3]) : 1'b1;
        end
    end

    task automatic send(input logic [31:0] p, input logic lst);
        bit acc;
        in_valid = 1'b1; in_pix = p; in_last = lst;
        do begin
            @(negedge clk);
            acc = in_ready;
            @(posedge clk);
            #4;
        end while (!acc);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic send_line(input int len, input int seed);
        for (int i = 0; i < len; i++) send(pixgen(seed + i), i == len - 1);
    endtask

    task automatic drain();
        do @(negedge clk); while (expq.size() != 0 || out_valid);
        check(lineq.size() == 0, cur_req, "line bytes left over", 64'(lineq.size()), 64'h0);
        @(posedge clk); #4;
    endtask

    task automatic setcfg(input logic [3:0] f, input logic ae, input logic ai,
                          input logic [3:0] be, input string req);
        cfg_fmt = f; cfg_alpha_en = ae; cfg_alpha_inv = ai; cfg_byte_en = be;
        cur_req = req;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #4 rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'h0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'h1);
        @(posedge clk); #4;

        // R2: 32-bit layouts
        for (int f = 12; f < 16; f++) begin
            setcfg(4'(f), 1'b1, 1'b0, 4'hF, "R2");
            send_line(3, f * 10);
            drain();
        end
        // R3 and R6: 4444 with odd line length
        for (int f = 0; f < 4; f++) begin
            setcfg(4'(f), 1'b1, 1'b0, 4'hF, "R3");
            send_line(4, f * 7);
            cur_req = "R6";
            send_line(5, f * 7 + 50);
            drain();
        end
        // R4: 565
        setcfg(4'd6, 1'b1, 1'b0, 4'hF, "R4"); send_line(4, 3); drain();
        setcfg(4'd7, 1'b0, 1'b1, 4'hF, "R4"); send_line(3, 9); drain();
        // R5 and R6: 24-bit, every residual count
        for (int f = 8; f < 10; f++) begin
            setcfg(4'(f), 1'b1, 1'b0, 4'hF, "R5");
            send_line(4, 1);
            cur_req = "R6";
            for (int len = 5; len < 9; len++) send_line(len, len * 3);
            drain();
        end
        // R7: stored alpha, inverted
        setcfg(4'd15, 1'b1, 1'b1, 4'hF, "R7"); send_line(3, 21); drain();
        setcfg(4'd1,  1'b1, 1'b1, 4'hF, "R7"); send_line(4, 22); drain();
        // R8: padding alpha
        setcfg(4'd13, 1'b0, 1'b1, 4'hF, "R8"); send_line(2, 30); drain();
        setcfg(4'd13, 1'b0, 1'b0, 4'hF, "R8"); send_line(2, 31); drain();
        setcfg(4'd2,  1'b0, 1'b1, 4'hF, "R8"); send_line(3, 32); drain();
        // R9: lane mask
        setcfg(4'd9,  1'b1, 1'b0, 4'h5, "R9"); send_line(5, 40); drain();
        setcfg(4'd14, 1'b1, 1'b0, 4'hA, "R9"); send_line(2, 41); drain();
        // R10: unused codes
        setcfg(4'd4,  1'b1, 1'b0, 4'hF, "R10"); send_line(2, 50); drain();
        setcfg(4'd5,  1'b1, 1'b0, 4'hF, "R10"); send_line(1, 51); drain();
        setcfg(4'd10, 1'b1, 1'b0, 4'hF, "R10"); send_line(2, 52); drain();
        setcfg(4'd11, 1'b1, 1'b0, 4'hF, "R10"); send_line(1, 53); drain();
        // R11: random backpressure, flush colliding with next line
        rand_ready = 1;
        setcfg(4'd8, 1'b1, 1'b0, 4'hF, "R11");
        for (int i = 0; i < 6; i++) send_line(5 + i, 60 + i * 11);
        drain();
        setcfg(4'd0, 1'b0, 1'b1, 4'h7, "R11");
        for (int i = 0; i < 6; i++) send_line(3 + i, 90 + i);
        drain();
        setcfg(4'd15, 1'b1, 1'b0, 4'hF, "R11");
        send_line(20, 7);
        drain();
        rand_ready = 0;

        summary();
        $finish;
    end
endmodule